// File: doc/BRIEF.md
# Serial Gain-Control Register Interface

This block is a write-only serial slave. It receives 16-bit control frames on three wires: an active-low select, a shift clock and a data line. It stores the data byte of each valid frame in either a transmit-gain register or a receive-gain register. The stored codes are decoded at all times into gain selections for three analog stages: one transmit attenuator and two cascaded receive amplifiers. For each stage the block drives a one-hot vector with one bit per gain step and a signed gain value in whole dB.

The serial inputs are asynchronous to the block clock. They pass through a synchronizer and are then edge-detected, so the serial clock must be several times slower than the block clock. A frame is committed when the select line returns high. It is committed only if exactly sixteen shift edges arrived while the select was low; any other frame leaves both registers unchanged.

Top module: `serial_gain_ctl`

## Requirements
- R1: While `ser_csn` is low, each rising edge of `ser_clk` samples `ser_din` as the next frame bit; each falling edge of `ser_csn` starts a new frame at bit 0.
- R2: Frame bit i is the i-th sampled bit. Bits 1..4 are address bits A0..A3 and bits 8..15 are data bits D0..D7. The values of bit 0 and bits 5..7 have no effect.
- R3: A frame is committed on the rising edge of `ser_csn` only if exactly 16 shift edges were sampled; frames with fewer or more edges change neither register.
- R4: A1=0 with A0=0 selects the transmit register and A1=0 with A0=1 selects the receive register; A3 and A2 are ignored.
- R5: A frame with A1=1 changes neither register.
- R6: Transmit code D2..D0: code n in 0..5 gives -2n dB; codes 6 and 7 give -12 dB.
- R7: First receive stage, code D3..D0: with D3=0 the gain is 3*D2..D0 dB; with D3=1 it is 24 dB whatever the lower bits are.
- R8: Second receive stage, code D7..D4: with D7=0 the gain is -9+3*D6..D4 dB; with D7=1, D6 and D5 are ignored, and D4=0 gives 15 dB while D4=1 gives 18 dB.
- R9: Bit k of each one-hot output is the only bit set. For the transmit stage it means -2k dB, for the first receive stage 3k dB and for the second receive stage -9+3k dB. The dB outputs are two's complement.
- R10: An active `rst_n` clears both registers and the bit counter, giving 0 dB transmit, 0 dB on the first receive stage and -9 dB on the second.
- R11: Shift-clock edges while `ser_csn` is high have no effect, and the registers hold between commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_csn | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data, sampled on the rising shift edge |
| tx_att_oh | output | 7 | One-hot transmit attenuator step |
| tx_att_db | output | 6 | Transmit gain in dB, signed |
| rx1_oh | output | 9 | One-hot first receive stage step |
| rx1_db | output | 6 | First receive stage gain in dB, signed |
| rx2_oh | output | 10 | One-hot second receive stage step |
| rx2_db | output | 6 | Second receive stage gain in dB, signed |

## Verification
Directed frames walk every transmit code and every receive nibble. This separates the linear part of each table from the saturating region and the region where some bits are ignored. Frames of 15 and 17 bits, frames with A1 set and frames whose lead and pad bits are ones each show whether the commit rule and the field positions are honoured. Shift-clock toggling while the select is high, followed by a reset, checks the hold and clear behaviour. Random frames of random length and address then run against a bench model of both registers and all three tables.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_POS   = 1;
  localparam int DATA_POS   = 8;
  localparam int DATA_W     = 8;
  localparam int TX_CODE_W  = 3;
  localparam int RX_CODE_W  = 4;
  localparam int TX_STEPS   = 7;
  localparam int RX1_STEPS  = 9;
  localparam int RX2_STEPS  = 10;
  localparam int DB_W       = 6;
  localparam int IDX_W      = 4;

  typedef enum logic [1:0] {STG_TX, STG_RX1, STG_RX2} stage_e;

  // step index of the transmit attenuator, saturating at the last step
  function automatic logic [IDX_W-1:0] tx_idx(input logic [TX_CODE_W-1:0] c);
    return (c > 3'd5) ? 4'd6 : {1'b0, c};
  endfunction

  // first receive stage: top bit forces the highest step
  function automatic logic [IDX_W-1:0] rx1_idx(input logic [RX_CODE_W-1:0] c);
    return c[3] ? 4'd8 : {1'b0, c[2:0]};
  endfunction

  // second receive stage: top bit selects one of two upper steps by c[0]
  function automatic logic [IDX_W-1:0] rx2_idx(input logic [RX_CODE_W-1:0] c);
    return c[3] ? (4'd8 + {3'b000, c[0]}) : {1'b0, c[2:0]};
  endfunction

  function automatic logic signed [DB_W-1:0] step_db(input logic [IDX_W-1:0] idx,
                                                     input int base, input int step);
    return DB_W'(base + step * int'(idx));
  endfunction
endpackage

// File: rtl/sgc_sync.sv
module sgc_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= raw;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl  = stg_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/sgc_capture.sv
module sgc_capture
  import sgc_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              shift_en,
  input  logic              din,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [1:0]        addr_lo,
  output logic [DATA_W-1:0] data
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        addr_q;
  logic [DATA_W-1:0] data_q;

  // bits are steered to their field by position; ignored positions are never stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (frame_start) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      for (int i = 0; i < 2; i++)
        if (cnt_q == CNT_W'(ADDR_POS + i)) addr_q[i] <= din;
      for (int i = 0; i < DATA_W; i++)
        if (cnt_q == CNT_W'(DATA_POS + i)) data_q[i] <= din;
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_cnt = cnt_q;
  assign addr_lo = addr_q;
  assign data    = data_q;
endmodule

// File: rtl/sgc_regs.sv
module sgc_regs
  import sgc_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_end,
  input  logic [CNT_W-1:0]     bit_cnt,
  input  logic [1:0]           addr_lo,
  input  logic [DATA_W-1:0]    data,
  output logic                 frame_ok,
  output logic                 commit_tx,
  output logic                 commit_rx,
  output logic [TX_CODE_W-1:0] tx_code,
  output logic [DATA_W-1:0]    rx_code
);
  logic [TX_CODE_W-1:0] tx_q;
  logic [DATA_W-1:0]    rx_q;

  assign frame_ok  = frame_end && (bit_cnt == CNT_W'(FRAME_BITS));
  assign commit_tx = frame_ok && (addr_lo == 2'b00);
  assign commit_rx = frame_ok && (addr_lo == 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (commit_tx) tx_q <= data[TX_CODE_W-1:0];
      if (commit_rx) rx_q <= data;
    end
  end

  assign tx_code = tx_q;
  assign rx_code = rx_q;
endmodule

// File: rtl/sgc_stage_decode.sv
module sgc_stage_decode
  import sgc_pkg::*;
#(
  parameter stage_e STAGE  = STG_TX,
  parameter int     CODE_W = TX_CODE_W,
  parameter int     STEPS  = TX_STEPS
) (
  input  logic [CODE_W-1:0]      code,
  output logic [STEPS-1:0]       oh,
  output logic signed [DB_W-1:0] db
);
  logic [IDX_W-1:0] idx;

  if (STAGE == STG_TX) begin : g_tx
    assign idx = tx_idx(code);
    assign db  = step_db(idx, 0, -2);
  end else if (STAGE == STG_RX1) begin : g_rx1
    assign idx = rx1_idx(code);
    assign db  = step_db(idx, 0, 3);
  end else begin : g_rx2
    assign idx = rx2_idx(code);
    assign db  = step_db(idx, -9, 3);
  end

  assign oh = STEPS'(1) << idx;
endmodule

// File: rtl/serial_gain_ctl.sv
module serial_gain_ctl
  import sgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_csn,
  input  logic                    ser_clk,
  input  logic                    ser_din,
  output logic [TX_STEPS-1:0]     tx_att_oh,
  output logic signed [DB_W-1:0]  tx_att_db,
  output logic [RX1_STEPS-1:0]    rx1_oh,
  output logic signed [DB_W-1:0]  rx1_db,
  output logic [RX2_STEPS-1:0]    rx2_oh,
  output logic signed [DB_W-1:0]  rx2_db
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic [2:0] s_lvl, s_rise, s_fall;
  logic       cs_rise, cs_fall, shift_en;
  logic [CNT_W-1:0]     bit_cnt;
  logic [1:0]           addr_lo;
  logic [DATA_W-1:0]    data;
  logic                 frame_ok, commit_tx, commit_rx;
  logic [TX_CODE_W-1:0] tx_code_q;
  logic [DATA_W-1:0]    rx_code_q;

  sgc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({ser_din, ser_clk, ser_csn}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign cs_rise  = s_rise[0];
  assign cs_fall  = s_fall[0];
  assign shift_en = s_rise[1] && !s_lvl[0];

  sgc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .frame_start(cs_fall), .shift_en(shift_en),
    .din(s_lvl[2]), .bit_cnt(bit_cnt), .addr_lo(addr_lo), .data(data)
  );

  sgc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_end(cs_rise), .bit_cnt(bit_cnt),
    .addr_lo(addr_lo), .data(data), .frame_ok(frame_ok),
    .commit_tx(commit_tx), .commit_rx(commit_rx),
    .tx_code(tx_code_q), .rx_code(rx_code_q)
  );

  sgc_stage_decode #(.STAGE(STG_TX), .CODE_W(TX_CODE_W), .STEPS(TX_STEPS)) u_dec_tx (
    .code(tx_code_q), .oh(tx_att_oh), .db(tx_att_db)
  );
  sgc_stage_decode #(.STAGE(STG_RX1), .CODE_W(RX_CODE_W), .STEPS(RX1_STEPS)) u_dec_rx1 (
    .code(rx_code_q[3:0]), .oh(rx1_oh), .db(rx1_db)
  );
  sgc_stage_decode #(.STAGE(STG_RX2), .CODE_W(RX_CODE_W), .STEPS(RX2_STEPS)) u_dec_rx2 (
    .code(rx_code_q[7:4]), .oh(rx2_oh), .db(rx2_db)
  );
endmodule

// File: rtl/sgc_checker.sv
module sgc_checker
  import sgc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frame_ok,
  input logic [1:0]              addr_lo,
  input logic [CNT_W-1:0]        bit_cnt,
  input logic [TX_CODE_W-1:0]    tx_code_q,
  input logic [DATA_W-1:0]       rx_code_q,
  input logic [TX_STEPS-1:0]     tx_att_oh,
  input logic [RX1_STEPS-1:0]    rx1_oh,
  input logic [RX2_STEPS-1:0]    rx2_oh,
  input logic signed [DB_W-1:0]  tx_att_db,
  input logic signed [DB_W-1:0]  rx2_db
);
  // R3
  tx_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_code_q) |-> $past(frame_ok));
  // R3
  rx_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_code_q) |-> $past(frame_ok));
  // R5
  upper_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && addr_lo[1]) |=> ($stable(tx_code_q) && $stable(rx_code_q)));
  // R11
  cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS + 1));
  // R9
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tx_att_oh) == 1) && ($countones(rx1_oh) == 1) && ($countones(rx2_oh) == 1));
  // R9
  tx_top_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_att_oh[TX_STEPS-1] |-> (tx_att_db == -6'sd12));
  // R8
  rx2_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx2_oh[0] |-> (rx2_db == -6'sd9));
  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tx_code_q == '0 && rx_code_q == '0 && bit_cnt == '0));
endmodule

bind serial_gain_ctl sgc_checker #(.CNT_W(CNT_W)) u_sgc_checker (
  .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .addr_lo(addr_lo),
  .bit_cnt(bit_cnt), .tx_code_q(tx_code_q), .rx_code_q(rx_code_q),
  .tx_att_oh(tx_att_oh), .rx1_oh(rx1_oh), .rx2_oh(rx2_oh),
  .tx_att_db(tx_att_db), .rx2_db(rx2_db)
);

// File: tb/serial_gain_ctl_bench.sv
module serial_gain_ctl_bench;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_csn = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic [6:0] tx_att_oh;
  logic [8:0] rx1_oh;
  logic [9:0] rx2_oh;
  logic signed [5:0] tx_att_db, rx1_db, rx2_db;

  int checks = 0;
  int errors = 0;
  logic [2:0] m_tx = '0;
  logic [7:0] m_rx = '0;

  always #5 clk = ~clk;

  serial_gain_ctl u_serial_gain_ctl (
    .clk(clk), .rst_n(rst_n), .ser_csn(ser_csn), .ser_clk(ser_clk), .ser_din(ser_din),
    .tx_att_oh(tx_att_oh), .tx_att_db(tx_att_db), .rx1_oh(rx1_oh), .rx1_db(rx1_db),
    .rx2_oh(rx2_oh), .rx2_db(rx2_db)
  );

  function automatic int exp_tx_db(input logic [2:0] c);
    int g = -2 * int'(c);
    return (g < -12) ? -12 : g;
  endfunction
  function automatic int exp_rx1_db(input logic [3:0] c);
    return c[3] ? 24 : 3 * int'(c[2:0]);
  endfunction
  function automatic int exp_rx2_db(input logic [3:0] c);
    if (c[3]) return c[0] ? 18 : 15;
    return 3 * int'(c[2:0]) - 9;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    int etx = exp_tx_db(m_tx);
    int er1 = exp_rx1_db(m_rx[3:0]);
    int er2 = exp_rx2_db(m_rx[7:4]);
    logic [6:0] otx = 7'(1) << (-etx / 2);
    logic [8:0] or1 = 9'(1) << (er1 / 3);
    logic [9:0] or2 = 10'(1) << ((er2 + 9) / 3);
    checks += 3;
    if (int'(tx_att_db) != etx || tx_att_oh != otx) begin
      errors++;
      $display("FAIL %s tx: got %0d/%b expected %0d/%b", tag, tx_att_db, tx_att_oh, etx, otx);
    end
    if (int'(rx1_db) != er1 || rx1_oh != or1) begin
      errors++;
      $display("FAIL %s rx1: got %0d/%b expected %0d/%b", tag, rx1_db, rx1_oh, er1, or1);
    end
    if (int'(rx2_db) != er2 || rx2_oh != or2) begin
      errors++;
      $display("FAIL %s rx2: got %0d/%b expected %0d/%b", tag, rx2_db, rx2_oh, er2, or2);
    end
  endtask

  // sends nbits of a frame; bits past 16 are random; junk fills lead and pad bits with ones
  task automatic send_frame(input logic [3:0] a, input logic [7:0] d,
                            input int nbits, input logic junk);
    logic [15:0] w = {d, {3{junk}}, a, junk};
    ser_csn = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 16) ? w[i] : 1'($urandom);
      tick(HALF);
      ser_clk = 1'b1;
      tick(HALF);
      ser_clk = 1'b0;
    end
    tick(HALF);
    ser_csn = 1'b1;
    tick(8);
    if (nbits == 16 && a[1] == 1'b0) begin
      if (a[0]) m_rx = d; else m_tx = d[2:0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(4);
    rst_n = 1'b1;
    tick(4);
    check_all("R10 reset state");

    for (int c = 0; c < 8; c++) begin
      send_frame(4'b0000, 8'(c) | 8'hF8, 16, 1'b0);
      check_all("R6 R9 tx code");
    end
    for (int c = 0; c < 16; c++) begin
      send_frame(4'b0001, {4'(c), 4'(15 - c)}, 16, 1'b0);
      check_all("R7 R8 R9 rx codes");
    end
    send_frame(4'b1101, 8'h93, 16, 1'b0);
    check_all("R4 A3 A2 ignored rx");
    send_frame(4'b1100, 8'h02, 16, 1'b0);
    check_all("R4 A3 A2 ignored tx");
    send_frame(4'b0010, 8'h57, 16, 1'b0);
    check_all("R5 A1 set ignored");
    send_frame(4'b0011, 8'hFF, 16, 1'b0);
    check_all("R5 A1 set ignored rx");
    send_frame(4'b0001, 8'h7C, 15, 1'b0);
    check_all("R3 short frame");
    send_frame(4'b0000, 8'h05, 17, 1'b0);
    check_all("R3 long frame");
    send_frame(4'b0001, 8'h45, 16, 1'b1);
    check_all("R2 lead and pad ignored");
    send_frame(4'b0000, 8'h04, 16, 1'b1);
    check_all("R1 R2 tx with pad ones");

    for (int i = 0; i < 20; i++) begin
      ser_din = 1'($urandom);
      tick(HALF); ser_clk = 1'b1; tick(HALF); ser_clk = 1'b0;
    end
    tick(8);
    check_all("R11 shift edges with select high");

    for (int n = 0; n < 150; n++) begin
      int r = int'($urandom_range(0, 9));
      int nb = (r < 6) ? 16 : (r == 6 ? 14 : (r == 7 ? 15 : (r == 8 ? 17 : 18)));
      send_frame(4'($urandom), 8'($urandom), nb, 1'($urandom));
      check_all("R3 R4 R5 R6 R7 R8 random frame");
    end

    send_frame(4'b0000, 8'h06, 16, 1'b0);
    send_frame(4'b0001, 8'hB9, 16, 1'b0);
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    m_tx = '0;
    m_rx = '0;
    tick(4);
    check_all("R10 reset after writes");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule